// File: doc/BRIEF.md
# Masked Vector Compress and Expand Unit

This unit rearranges the lanes of one vector register under a per-lane select mask. In pack mode it collects the selected lanes and lays them down side by side, starting at output slot 0. Slots left over are cleared. In spread mode it does the reverse: a dense run of elements is handed out, one by one, to the lanes whose mask bit is set. Lanes that are not selected keep the value of a passthrough vector. The number of set mask bits comes out together with the result.

Each lane's destination, or each lane's source in spread mode, is the exclusive prefix count of the mask bits below it. This makes element positions depend on the data rather than on fixed wiring. Operands enter on a valid/ready handshake. The result is registered and offered on a second valid/ready pair one cycle after the input is accepted.

Top module: `vcx_unit`

## Requirements
- R1: With in_mode = 0 (pack), the lanes with a set mask bit appear in ascending lane order in output slots 0, 1, 2, ... For example, mask 8'b1010_1100 on x0..x7 gives x2, x3, x5, x7 in slots 0..3. Lane i occupies bits [i*W +: W] of every vector port.
- R2: In pack mode, every output slot at or above the number of set mask bits is zero.
- R3: With in_mode = 1 (spread), the lane holding the k-th set mask bit, counted upward from lane 0 with k starting at 0, receives dense input element k (lane k of in_data).
- R4: In spread mode, every lane whose mask bit is 0 takes the same lane of in_pass.
- R5: out_count equals the number of set mask bits of the accepted operand, from 0 up to N. An all-zero mask gives count 0, an all-zero pack result and a spread result equal to in_pass.
- R6: An operand is accepted on a clock edge where in_valid and in_ready are both high. At the next edge, out_valid is high and out_data and out_count hold its result.
- R7: While out_valid is high and out_ready is low, in_ready is low and out_data and out_count stay unchanged.
- R8: After reset, out_valid is low and in_ready is high.
- R9: When a result is taken and a new operand is offered in the same cycle, both transfers happen at that edge. The new result follows on the next cycle, with no result lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand |
| in_mode | input | 1 | 0 = pack, 1 = spread |
| in_mask | input | N | Lane select mask |
| in_data | input | N*W | Source vector (sparse in pack, dense in spread) |
| in_pass | input | N*W | Passthrough vector for unselected lanes in spread |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | N*W | Result vector |
| out_count | output | $clog2(N+1) | Number of set mask bits |

## Verification
Retiring a held result and accepting a new operand can happen on the same edge. The sweep provokes this on every vector: each new operand is driven in the cycle in which the previous result is still shown and out_ready is high. Every result is then compared with a value computed independently, once and in order. A separate stall episode holds out_ready low while a second operand waits. Then out_ready is released, and the bench checks that the held result stays frozen and that the waiting operand is the next one seen.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  typedef enum logic {
    VCX_PACK   = 1'b0,
    VCX_SPREAD = 1'b1
  } vcx_mode_e;
endpackage

// File: rtl/vcx_prefix.sv
module vcx_prefix #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]    mask,
  output logic [N*CW-1:0] rank,
  output logic [CW-1:0]   total
);
  function automatic logic [CW-1:0] bump(input logic [CW-1:0] acc, input logic bit_in);
    return acc + {{(CW-1){1'b0}}, bit_in};
  endfunction

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    rank = '0;
    for (int i = 0; i < N; i++) begin
      rank[i*CW +: CW] = acc;
      acc = bump(acc, mask[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/vcx_permute.sv
module vcx_permute
  import vcx_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 32,
  parameter int CW = $clog2(N + 1)
) (
  input  vcx_mode_e        mode,
  input  logic [N-1:0]     mask,
  input  logic [N*W-1:0]   data,
  input  logic [N*W-1:0]   pass,
  input  logic [N*CW-1:0]  rank,
  output logic [N*W-1:0]   result
);
  logic [N*W-1:0] packed_v;
  logic [N*W-1:0] spread_v;

  always_comb begin
    packed_v = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) packed_v[int'(rank[i*CW +: CW])*W +: W] = data[i*W +: W];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [CW-1:0] src;
    assign src = rank[g*CW +: CW];
    assign spread_v[g*W +: W] = mask[g] ? data[int'(src)*W +: W] : pass[g*W +: W];
  end

  assign result = (mode == VCX_SPREAD) ? spread_v : packed_v;
endmodule

// File: rtl/vcx_outreg.sv
module vcx_outreg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] d,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] q
);
  logic valid_q;
  logic take;

  assign in_ready  = !valid_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      q       <= '0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        q       <= d;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  a_r6_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q)));
  a_r7_block: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/vcx_unit.sv
module vcx_unit
  import vcx_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 32,
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_mode,
  input  logic [N-1:0]   in_mask,
  input  logic [N*W-1:0] in_data,
  input  logic [N*W-1:0] in_pass,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N*W-1:0] out_data,
  output logic [CW-1:0]  out_count
);
  localparam int PW = 1 + CW + N * W;

  vcx_mode_e       mode;
  logic [N*CW-1:0] rank;
  logic [CW-1:0]   total;
  logic [N*W-1:0]  result;
  logic [PW-1:0]   payload_d;
  logic [PW-1:0]   payload_q;
  logic            mode_q;
  logic            tail_dirty;
  logic            accept;

  assign mode = vcx_mode_e'(in_mode);

  vcx_prefix #(.N(N), .CW(CW)) u_prefix (
    .mask(in_mask), .rank(rank), .total(total)
  );

  vcx_permute #(.N(N), .W(W), .CW(CW)) u_permute (
    .mode(mode), .mask(in_mask), .data(in_data), .pass(in_pass),
    .rank(rank), .result(result)
  );

  assign payload_d = {in_mode, total, result};

  vcx_outreg #(.PW(PW)) u_outreg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d(payload_d), .out_valid(out_valid), .out_ready(out_ready), .q(payload_q)
  );

  assign mode_q    = payload_q[PW-1];
  assign out_count = payload_q[N*W +: CW];
  assign out_data  = payload_q[N*W-1:0];
  assign accept    = in_valid && in_ready;

  always_comb begin
    tail_dirty = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (j >= int'(out_count) && out_data[j*W +: W] != '0) tail_dirty = 1'b1;
    end
  end

  a_r2_tail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == 1'b0) |-> !tail_dirty);
  a_r5_count: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_count == $past(CW'($countones(in_mask)))));
  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_count) <= N));
endmodule

// File: tb/sim_vcx_unit.sv
module sim_vcx_unit;
  localparam int N  = 8;
  localparam int W  = 32;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_mode = 1'b0;
  logic [N-1:0] in_mask = '0;
  logic [N*W-1:0] in_data = '0;
  logic [N*W-1:0] in_pass = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [N*W-1:0] out_data;
  logic [CW-1:0] out_count;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vcx_unit #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_mask(in_mask), .in_data(in_data), .in_pass(in_pass),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_count(out_count)
  );

  task automatic check(input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] model(input logic m, input logic [N-1:0] mk,
                                           input logic [N*W-1:0] d, input logic [N*W-1:0] p);
    logic [N*W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < N; i++) begin
      if (!m) begin
        if (mk[i]) begin r[k*W +: W] = d[i*W +: W]; k++; end
      end else begin
        if (mk[i]) begin r[i*W +: W] = d[k*W +: W]; k++; end
        else r[i*W +: W] = p[i*W +: W];
      end
    end
    return r;
  endfunction

  function automatic int ones(input logic [N-1:0] mk);
    int c = 0;
    for (int i = 0; i < N; i++) if (mk[i]) c++;
    return c;
  endfunction

  function automatic logic [N*W-1:0] mk_data(input int seed);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = 32'hC000_0000 + (seed << 8) + i;
    return v;
  endfunction

  function automatic logic [N*W-1:0] mk_pass();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = 32'h7700_0000 + i;
    return v;
  endfunction

  // called at a negedge; result is checked at the following negedge
  task automatic push(input logic m, input logic [N-1:0] mk, input int seed);
    logic [N*W-1:0] d;
    d = mk_data(seed);
    in_mode = m; in_mask = mk; in_data = d; in_pass = mk_pass(); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 out_valid", {{(N*W-1){1'b0}}, out_valid}, 1);
    check(m ? "R3 R4 spread" : "R1 R2 pack", out_data, model(m, mk, d, mk_pass()));
    check("R5 count", {{(N*W-CW){1'b0}}, out_count}, (N*W)'(ones(mk)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N*W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 out_valid", {{(N*W-1){1'b0}}, out_valid}, 0);
    check("R8 in_ready", {{(N*W-1){1'b0}}, in_ready}, 1);

    // exhaustive sweep: each push lands while the previous result is shown (R9)
    for (int m = 0; m < 2; m++)
      for (int mk = 0; mk < (1 << N); mk++)
        push(m[0], mk[N-1:0], mk);

    // corner masks
    push(1'b0, 8'b1010_1100, 1);
    check("R1 example slot0", {{(N*W-W){1'b0}}, out_data[0 +: W]}, (N*W)'(32'hC000_0102));
    push(1'b1, '0, 2);
    check("R5 zero spread passthrough", out_data, mk_pass());

    // stall episode (R7, R9)
    @(negedge clk);
    out_ready = 1'b0;
    push(1'b0, 8'hF0, 3);
    held = out_data;
    in_mode = 1'b1; in_mask = 8'h0F; in_data = mk_data(4); in_valid = 1'b1;
    #0.1;
    check("R7 in_ready low", {{(N*W-1){1'b0}}, in_ready}, 0);
    repeat (3) @(negedge clk);
    check("R7 held data", out_data, held);
    check("R7 held count", {{(N*W-CW){1'b0}}, out_count}, 4);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next result", out_data, model(1'b1, 8'h0F, mk_data(4), mk_pass()));
    @(negedge clk);
    check("R9 drained", {{(N*W-1){1'b0}}, out_valid}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule